// File: doc/BRIEF.md
# EEPROM Write Status Reporter

This block sits between the array read path of an electrically erasable memory and the host, and reports when an internal programming cycle has finished. A programming cycle opens with the first write strobe. From then until the programming engine drops its busy flag, the block supports three independent ways of detecting completion, and a host may use any of them at the same time.

The first is an open-drain ready/busy line, which is pulled low for the whole cycle. The second replaces bit 7 of each active byte lane of a read with the complement of the same bit of the last word loaded. The third replaces bit 6 of each active byte lane with a bit that flips on every read.

When no cycle is in progress, array data reaches the host unchanged. A host that polls in one of these ways can start its next operation as soon as completion shows, and need not wait out the worst-case write time. The open-drain pin is modelled as an enable with a data value that is always low, so that several devices can share one wired-OR line.

Top module: `eeprom_status_rep`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rb_oe` is 0 and `host_rdata` equals `array_rdata`.
- R2: Outside a programming cycle, `host_rdata` equals `array_rdata` whatever `rd_strobe`, `last_word` and `wide_mode` do.
- R3: `rb_oe` is 1 in the cycle after a clock edge that samples `wr_strobe` high, and `rb_level` is 0 at all times.
- R4: If `engine_busy` was 1 at one clock edge and is 0 at the next, with `wr_strobe` low, the programming cycle ends and `rb_oe` is 0 after that edge.
- R5: During a programming cycle, `host_rdata[7]` is the complement of `last_word[7]`.
- R6: When `wide_mode` is 1, bit 8k+7 of every byte lane k reads as the complement of `last_word[8k+7]` during a cycle. When `wide_mode` is 0, only lane 0 is substituted, and bits 8 and up pass `array_rdata` through.
- R7: The toggle bit (bit 6 of each active lane) reads 1 in the first cycle after every write strobe, including when an earlier cycle left it at 0.
- R8: During a cycle, each clock edge that samples `rd_strobe` high inverts the toggle bit. Without a read strobe it holds its value.
- R9: During a cycle, bits 5..0 of every lane, and both substituted bits of lanes that are not active, come from `array_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 1 | One-cycle pulse marking a write strobe; opens a programming cycle |
| engine_busy | input | 1 | Busy flag from the programming engine |
| last_word | input | DW | Last data word loaded for programming |
| wide_mode | input | 1 | 1: all byte lanes report status; 0: lane 0 only |
| rd_strobe | input | 1 | One-cycle pulse per completed host read |
| array_rdata | input | DW | Read data from the array |
| host_rdata | output | DW | Read data returned to the host |
| rb_oe | output | 1 | Enable of the open-drain ready/busy driver (1 = pull low) |
| rb_level | output | 1 | Value driven when enabled; always 0 |

## Verification
The assertions assume that `engine_busy` is low during reset and that a programming cycle ends only on a falling edge of `engine_busy`. They also assume that `rd_strobe` and `wr_strobe` are single-cycle pulses sampled at clock edges. The stimulus holds `engine_busy` low through reset and raises it only after a write strobe. It changes inputs only at the falling clock edge and keeps `wide_mode` stable within each read. The toggle-restart check runs a second cycle after the first one has left the toggle at 0.

// File: rtl/eeprom_status_rep.sv
`timescale 1ns/1ps
module eeprom_status_rep #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_strobe,
  input  logic          engine_busy,
  input  logic [DW-1:0] last_word,
  input  logic          wide_mode,
  input  logic          rd_strobe,
  input  logic [DW-1:0] array_rdata,
  output logic [DW-1:0] host_rdata,
  output logic          rb_oe,
  output logic          rb_level
);
  localparam int LANES = DW / 8;

  logic in_prog, busy_d, tog;
  logic prog_done;

  assign prog_done = busy_d & ~engine_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_prog <= 1'b0;
      busy_d  <= 1'b0;
      tog     <= 1'b1;
    end else begin
      busy_d <= engine_busy;
      if (wr_strobe) begin
        in_prog <= 1'b1;
        tog     <= 1'b1;
      end else begin
        if (prog_done) in_prog <= 1'b0;
        if (in_prog && rd_strobe) tog <= ~tog;
      end
    end
  end

  assign rb_oe    = in_prog;
  assign rb_level = 1'b0;

  always_comb begin
    host_rdata = array_rdata;
    if (in_prog) begin
      for (int k = 0; k < LANES; k++) begin
        if (k == 0 || wide_mode) begin
          host_rdata[8*k+7] = ~last_word[8*k+7];
          host_rdata[8*k+6] = tog;
        end
      end
    end
  end
endmodule

module eeprom_status_rep_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_strobe,
  input logic          engine_busy,
  input logic [DW-1:0] last_word,
  input logic          wide_mode,
  input logic          rd_strobe,
  input logic [DW-1:0] array_rdata,
  input logic [DW-1:0] host_rdata,
  input logic          rb_oe,
  input logic          rb_level
);
  // R3
  strobe_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> rb_oe);

  // R4
  busy_fall_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(engine_busy) && !engine_busy && !wr_strobe) |=> !rb_oe);

  // R2
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_oe |-> host_rdata == array_rdata);

  // R5
  poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_oe |-> host_rdata[7] == ~last_word[7]);

  // R6
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_oe && !wide_mode) |-> host_rdata[DW-1:8] == array_rdata[DW-1:8]);

  // R7
  toggle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> host_rdata[6]);

  // R8
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_oe && rd_strobe && !wr_strobe) |=> (!rb_oe || host_rdata[6] != $past(host_rdata[6])));

  // R9
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_oe |-> host_rdata[5:0] == array_rdata[5:0]);
endmodule

bind eeprom_status_rep eeprom_status_rep_chk #(.DW(DW)) u_chk (.*);

// File: tb/test_eeprom_status_rep.sv
`timescale 1ns/1ps
module test_eeprom_status_rep;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_strobe = 1'b0;
  logic          engine_busy = 1'b0;
  logic [DW-1:0] last_word = '0;
  logic          wide_mode = 1'b0;
  logic          rd_strobe = 1'b0;
  logic [DW-1:0] array_rdata = '0;
  logic [DW-1:0] host_rdata;
  logic          rb_oe;
  logic          rb_level;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit m_prog = 0;
  bit m_tog = 1;
  bit m_bprev = 0;

  always #5 clk = ~clk;

  eeprom_status_rep #(.DW(DW)) i_eeprom_status_rep (.*);

  function automatic logic [DW-1:0] expect_data();
    logic [DW-1:0] d = array_rdata;
    if (m_prog) begin
      for (int k = 0; k < DW / 8; k++) begin
        if (k == 0 || wide_mode) begin
          d[8*k+7] = ~last_word[8*k+7];
          d[8*k+6] = m_tog;
        end
      end
    end
    return d;
  endfunction

  task automatic compare(input string req);
    logic [DW-1:0] e = expect_data();
    checks++;
    if (rb_oe !== m_prog || rb_level !== 1'b0 || host_rdata !== e) begin
      errors++;
      $display("FAIL %s: oe=%0b lvl=%0b data=%h expected oe=%0b lvl=0 data=%h",
               req, rb_oe, rb_level, host_rdata, m_prog, e);
    end
  endtask

  // Inputs set at the falling edge; compare; then advance model at rising edge.
  task automatic step(input string req, input bit ws, input bit eb, input bit rs,
                      input logic [DW-1:0] arr);
    wr_strobe = ws; engine_busy = eb; rd_strobe = rs; array_rdata = arr;
    #1;
    compare(req);
    @(posedge clk);
    if (rst_n) begin
      if (ws) begin
        m_prog = 1; m_tog = 1;
      end else begin
        if (m_bprev && !eb) m_prog = 0;
        if (m_prog && rs) m_tog = ~m_tog;
      end
      m_bprev = eb;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    step("R1", 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF);
    step("R1", 1'b1, 1'b0, 1'b1, 32'h1234_5678);
    rst_n = 1'b1;
    step("R1", 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF);

    // R2 idle passthrough
    last_word = 32'hFFFF_FFFF; wide_mode = 1'b1;
    step("R2", 1'b0, 1'b0, 1'b1, 32'h0000_0000);
    step("R2", 1'b0, 1'b0, 1'b1, 32'hC0C0_C0C0);
    step("R2", 1'b0, 1'b0, 1'b0, 32'h3F3F_3F3F);

    // R3 open cycle, byte mode
    wide_mode = 1'b0; last_word = 32'h0080_7F80;
    step("R3", 1'b1, 1'b0, 1'b0, 32'hAAAA_AAAA);
    // R7 first read shows toggle 1; R5 poll bit
    step("R7", 1'b0, 1'b1, 1'b1, 32'h5555_5555);
    // R8 flips
    step("R8", 1'b0, 1'b1, 1'b0, 32'h5555_5555);
    step("R8", 1'b0, 1'b1, 1'b1, 32'h0000_0000);
    step("R8", 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    // R5 and R9
    step("R5", 1'b0, 1'b1, 1'b0, 32'h1357_9BDF);
    step("R9", 1'b0, 1'b1, 1'b0, 32'hFFFF_FF3F);
    // R6 wide mode
    wide_mode = 1'b1;
    step("R6", 1'b0, 1'b1, 1'b1, 32'h0000_0000);
    last_word = 32'h8000_8000;
    step("R6", 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    wide_mode = 1'b0;
    step("R6", 1'b0, 1'b1, 1'b1, 32'hC3C3_C3C3);
    // R4 end of cycle
    step("R4", 1'b0, 1'b0, 1'b0, 32'h2468_ACE0);
    step("R4", 1'b0, 1'b0, 1'b1, 32'h2468_ACE0);
    step("R2", 1'b0, 1'b0, 1'b1, 32'h8888_8888);

    // R7 restart after a cycle ended with toggle 0
    wide_mode = 1'b1; last_word = 32'h7F7F_7F7F;
    step("R7", 1'b1, 1'b0, 1'b0, 32'h0000_0000);
    step("R7", 1'b0, 1'b1, 1'b1, 32'h0000_0000);
    step("R7", 1'b1, 1'b1, 1'b0, 32'h0000_0000);
    step("R7", 1'b0, 1'b1, 1'b0, 32'h0000_0000);
    step("R8", 1'b0, 1'b1, 1'b0, 32'h0000_0000);
    step("R4", 1'b0, 1'b0, 1'b1, 32'h0F0F_0F0F);
    step("R4", 1'b0, 1'b0, 1'b0, 32'h0F0F_0F0F);

    // R3 strobe with busy already low keeps cycle open until busy falls
    step("R3", 1'b1, 1'b0, 1'b0, 32'h1111_1111);
    step("R3", 1'b0, 1'b0, 1'b0, 32'h1111_1111);
    step("R3", 1'b0, 1'b0, 1'b0, 32'h1111_1111);
    step("R3", 1'b0, 1'b1, 1'b0, 32'h1111_1111);
    step("R4", 1'b0, 1'b0, 1'b0, 32'h1111_1111);
    step("R2", 1'b0, 1'b0, 1'b0, 32'h1111_1111);

    finish_run();
  end
endmodule